// File: doc/BRIEF.md
# Mode-Switched Readout Word Queue

This block is a small first-in first-out queue of 16-bit words placed between on-chip data producers and a serial register port. A mode input selects one of three behaviours. In message mode the queue holds up to eight words, refuses writes once full and remembers in a sticky flag that a write was refused. In monitoring mode it holds converter results: the low 12 bits are the conversion value and the upper 4 bits name the channel it came from. Only seven slots are used, and a write to a full queue discards the oldest entry, so the seven newest results are always kept. In table-load mode the host can only write. Words wait there for a non-volatile memory writer, which drains them through its own read strobe. Up to eight words are held, and writes beyond that are discarded.

In every mode the oldest stored word leaves first. The host read data is combinational from the head of the queue and is valid in the same cycle as the read strobe. A pop takes effect at the next rising edge. Changing the mode empties the queue.

Top module: `mode_fifo`

## Requirements
- R1: After reset the queue is empty: `empty`=1, `full`=0, `count`=0 and `drop_flag`=0.
- R2: In message mode (`mode_sel`=00), `host_data` shows the oldest stored word, and each `host_rd` on a non-empty queue advances to the next word in write order.
- R3: In monitoring mode (`mode_sel`=01), `full` rises at seven entries. A `push` while full discards the oldest entry and keeps `count` at 7, so the seven newest words remain in order.
- R4: In monitoring mode, the stored word is `{mon_tag[3:0], push_data[11:0]}`: the tag is in bits 15:12 and the result is in bits 11:0. `push_data[15:12]` is ignored.
- R5: In message mode, `full` rises at eight entries. A `push` while full leaves the contents and `count` unchanged and sets `drop_flag`, which stays set until reset or a mode change.
- R6: In table-load mode (`mode_sel`=1x), `host_data` reads zero and `host_rd` leaves `count` unchanged. A push to a full queue of eight is discarded. `nvm_rd` pops the oldest word, which is shown on `nvm_data`.
- R7: In any cycle where `mode_sel` differs from the mode of the previous cycle, the queue is emptied and `drop_flag` is cleared at the next edge. A `push` or a pop in that cycle has no effect.
- R8: A push and a pop in the same cycle on a queue that is neither empty nor full leave `count` unchanged and keep the order of the words.
- R9: Outside table-load mode `nvm_rd` has no effect. A pop on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | 00 message, 01 monitoring, 1x table-load |
| push | input | 1 | Write strobe from the producer or the host |
| push_data | input | 16 | Word to write |
| mon_tag | input | 4 | Channel tag stored with a monitoring result |
| host_rd | input | 1 | Host read strobe, pops the head outside table-load mode |
| host_data | output | 16 | Head word for the host, zero when empty or in table-load mode |
| nvm_rd | input | 1 | Drain strobe of the memory writer, active in table-load mode |
| nvm_data | output | 16 | Head word for the memory writer in table-load mode, zero otherwise |
| full | output | 1 | Count equals the depth of the current mode |
| empty | output | 1 | Count is zero |
| count | output | 4 | Number of stored words |
| drop_flag | output | 1 | Sticky record of a refused message-mode write |

## Verification
`count`, `full`, `empty` and `drop_flag` are registered, so their new values are due one rising edge after the strobe. `host_data` and `nvm_data` follow the head pointer without delay: they show the word to be popped in the same cycle as the strobe, and the next word after the edge. The bench drives inputs one time unit after a rising edge and samples the outputs at the same point, after the edge that consumed the stimulus. It reads each head word before issuing the pop that removes it. A mode change is checked one edge after `mode_sel` moves.

// File: rtl/mode_fifo.sv
module mode_fifo #(
  parameter int WIDTH     = 16,
  parameter int DEPTH     = 8,
  parameter int MON_DEPTH = 7,
  parameter int RES_W     = 12,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int TW       = WIDTH - RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic [TW-1:0]    mon_tag,
  input  logic             host_rd,
  output logic [WIDTH-1:0] host_data,
  input  logic             nvm_rd,
  output logic [WIDTH-1:0] nvm_data,
  output logic             full,
  output logic             empty,
  output logic [CW-1:0]    count,
  output logic             drop_flag
);

  localparam logic [1:0] M_MSG = 2'b00;
  localparam logic [1:0] M_MON = 2'b01;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [1:0]       mode_q;
  logic             chg, is_mon, is_str, do_pop, do_wr, ovr, inc, dec;
  logic [CW-1:0]    limit;
  logic [WIDTH-1:0] wdata, head;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign chg    = mode_sel != mode_q;
  assign is_mon = mode_q == M_MON;
  assign is_str = mode_q[1];
  assign limit  = is_mon ? CW'(MON_DEPTH) : CW'(DEPTH);
  assign full   = count == limit;
  assign empty  = count == '0;
  assign do_pop = !chg && !empty && (is_str ? nvm_rd : host_rd);
  assign do_wr  = !chg && push && (!full || is_mon);
  assign ovr    = do_wr && full;
  assign inc    = do_wr && !full;
  assign dec    = do_pop && !ovr;
  assign wdata  = is_mon ? {mon_tag, push_data[RES_W-1:0]} : push_data;
  assign head   = mem[rd_ptr];

  assign host_data = (is_str || empty) ? '0 : head;
  assign nvm_data  = (is_str && !empty) ? head : '0;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_MSG;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      count     <= '0;
      drop_flag <= 1'b0;
    end else if (chg) begin
      mode_q    <= mode_sel;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      count     <= '0;
      drop_flag <= 1'b0;
    end else begin
      if (do_wr)          wr_ptr <= nxt(wr_ptr);
      if (do_pop || ovr)  rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(inc) - CW'(dec);
      if (mode_q == M_MSG && push && full) drop_flag <= 1'b1;
    end
  end

  AST_MON_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    is_mon |-> count <= CW'(MON_DEPTH)); // R3

  AST_MON_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && is_mon && push && full) |=> count == CW'(MON_DEPTH)); // R3

  AST_MSG_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && mode_q == M_MSG && push && full && !host_rd) |=> ($stable(count) && drop_flag)); // R5

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (empty && !drop_flag)); // R7

  AST_STREAM_HOST_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && is_str && host_rd && !nvm_rd && !push) |=> $stable(count)); // R6

  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg && !is_str && push && host_rd && !empty && !full) |=> $stable(count)); // R8

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty); // R9

endmodule

// File: tb/mode_fifo_tb_top.sv
module mode_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic        push = 1'b0, host_rd = 1'b0, nvm_rd = 1'b0;
  logic [15:0] push_data = '0;
  logic [3:0]  mon_tag = '0;
  logic [15:0] host_data, nvm_data;
  logic        full, empty, drop_flag;
  logic [3:0]  count;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  mode_fifo dut_i (.clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .push(push),
    .push_data(push_data), .mon_tag(mon_tag), .host_rd(host_rd), .host_data(host_data),
    .nvm_rd(nvm_rd), .nvm_data(nvm_data), .full(full), .empty(empty), .count(count),
    .drop_flag(drop_flag));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    push = 0; host_rd = 0; nvm_rd = 0;
  endtask

  task automatic wr(input logic [15:0] d, input logic [3:0] t = 4'h0);
    push = 1; push_data = d; mon_tag = t; step();
  endtask

  task automatic t_reset();
    chk("R1 empty", empty, 1); chk("R1 full", full, 0);
    chk("R1 count", count, 0); chk("R1 drop", drop_flag, 0);
  endtask

  task automatic t_message();
    for (int i = 0; i < 8; i++) wr(16'hA000 + 16'(i));
    chk("R5 full at 8", full, 1); chk("R5 count 8", count, 8);
    wr(16'hBEEF);
    chk("R5 count kept", count, 8); chk("R5 drop flag", drop_flag, 1);
    for (int i = 0; i < 8; i++) begin
      chk("R2 order", host_data, 16'hA000 + 16'(i));
      host_rd = 1; step();
    end
    chk("R2 empty after drain", empty, 1);
    chk("R5 flag sticky", drop_flag, 1);
    host_rd = 1; step();
    chk("R9 pop on empty", count, 0);
  endtask

  task automatic t_push_pop();
    for (int i = 0; i < 3; i++) wr(16'h1100 + 16'(i));
    chk("R8 head", host_data, 16'h1100);
    push = 1; push_data = 16'h1103; host_rd = 1; step();
    chk("R8 count held", count, 3);
    for (int i = 1; i < 4; i++) begin
      chk("R8 order", host_data, 16'h1100 + 16'(i));
      host_rd = 1; step();
    end
    chk("R8 empty", empty, 1);
    wr(16'h2222); wr(16'h3333);
    nvm_rd = 1; step();
    chk("R9 nvm_rd ignored", count, 2);
    chk("R9 head kept", host_data, 16'h2222);
  endtask

  task automatic t_mode_change();
    mode_sel = 2'b01; push = 1; push_data = 16'h0555; step();
    chk("R7 emptied", empty, 1); chk("R7 count", count, 0);
    chk("R7 drop cleared", drop_flag, 0);
  endtask

  task automatic t_monitor();
    for (int i = 0; i < 10; i++) wr({4'hF, 12'(i * 3 + 1)}, 4'(i));
    chk("R3 full at 7", full, 1); chk("R3 count 7", count, 7);
    for (int i = 3; i < 10; i++) begin
      chk("R3 R4 newest kept with tag", host_data, {4'(i), 12'(i * 3 + 1)});
      host_rd = 1; step();
    end
    chk("R3 empty", empty, 1);
  endtask

  task automatic t_stream();
    mode_sel = 2'b10; step();
    chk("R7 stream empty", count, 0);
    for (int i = 0; i < 9; i++) wr(16'hC000 + 16'(i));
    chk("R6 count 8", count, 8); chk("R6 full", full, 1);
    chk("R6 host data zero", host_data, 0);
    host_rd = 1; step();
    chk("R6 host rd no pop", count, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R6 drain order", nvm_data, 16'hC000 + 16'(i));
      nvm_rd = 1; step();
    end
    chk("R6 drained", empty, 1);
  endtask

  initial begin
    #3 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_message();
    t_push_pop();
    t_mode_change();
    t_monitor();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule